// File: doc/BRIEF.md
# Interrupt Mask Register Bank

This block is the interrupt front end of a serial bus master engine. Sixteen level-sensitive interrupt sources are registered into a raw condition word. A 64-bit enable mask is combined with that word to form a masked condition word. A single level interrupt line goes high whenever any masked bit is set. Software reaches all of this through a small synchronous register port with three live word offsets.

The two condition words are read-only. Their offsets are shared by direction. A read returns the condition view. A write to the same offset atomically sets mask bits (OR) or keeps only selected mask bits (AND), so software never needs a read-modify-write sequence. A source bit stays visible for as long as its input is held and cannot be cleared by any write. It clears only when the condition that drives it goes away.

Top module: `irq_bank`

## Requirements
- R1: After reset the mask is all zeros, the read data is zero and `irq_o` is low.
- R2: A write to offset 0x8 replaces the mask with the write data restricted to bits 47..32. All other mask bits stay zero, and no read ever returns a set bit outside 47..32.
- R3: A write to offset 0x9 sets the mask to its old value OR the write data (bits 47..32 only).
- R4: A write to offset 0xA sets the mask to its old value AND the write data.
- R5: A read of offset 0x9 returns the raw condition. Source `src_lvl[i]` appears at bit 47-i: `src_lvl[0]` (invalid command) is at bit 47, `src_lvl[1]` (local-bus parity error) is at bit 46, and `src_lvl[15]` is at bit 32.
- R6: A read of offset 0xA returns the raw condition AND the mask. A read of offset 0x8 returns the mask.
- R7: `irq_o` is high exactly when the raw condition AND the mask is non-zero.
- R8: A raw condition bit follows its input level and is not changed by a write to any offset.
- R9: A read of any offset other than 0x8, 0x9 and 0xA returns zero. A write to such an offset leaves the mask unchanged.
- R10: Read data appears one cycle after the read strobe and is taken from the state before any write in the same cycle. It holds its value in cycles without a read strobe.
- R11: A source change is registered on the clock edge that follows it. A write and a source change in the same cycle are both visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Word offset of the access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Registered read data |
| src_lvl | input | 16 | Level interrupt sources |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench uses the default parameters: sixteen sources placed at bits 47..32, a 4-bit offset and the live offsets 8, 9 and 10. With a 4-bit offset the bench can reach every decode value, so it probes both inside and outside the three live offsets. The full source width lets it reach both end bits of the field, 47 and 32, and so confirm the reversed bit order. It also sets all mask bits at once to check that bits outside the field stay zero.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [1:0] {
    MOP_NONE = 2'd0,
    MOP_LOAD = 2'd1,
    MOP_SET  = 2'd2,
    MOP_CLR  = 2'd3
  } mask_op_e;

  typedef enum logic [1:0] {
    RSEL_ZERO   = 2'd0,
    RSEL_MASK   = 2'd1,
    RSEL_RAW    = 2'd2,
    RSEL_MASKED = 2'd3
  } read_sel_e;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_bank_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int SRC_N     = 16,
  parameter int FIELD_LSB = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mask_op_e          op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mask_o
);

  localparam logic [DATA_W-1:0] FIELD_MASK =
    {{(DATA_W-SRC_N){1'b0}}, {SRC_N{1'b1}}} << FIELD_LSB;

  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] mask_d;
  logic              mask_en;

  always_comb begin
    mask_en = 1'b1;
    mask_d  = mask_q;
    unique case (op)
      MOP_LOAD: mask_d = wdata & FIELD_MASK;
      MOP_SET:  mask_d = (mask_q | wdata) & FIELD_MASK;
      MOP_CLR:  mask_d = mask_q & wdata & FIELD_MASK;
      default:  mask_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/irq_cond_view.sv
module irq_cond_view #(
  parameter int DATA_W    = 64,
  parameter int SRC_N     = 16,
  parameter int FIELD_LSB = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_lvl,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] raw_o,
  output logic [DATA_W-1:0] masked_o,
  output logic              irq_o
);

  logic [SRC_N-1:0]  lvl_q;
  logic [DATA_W-1:0] raw_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      lvl_q <= src_lvl;
    end
  end

  // source 0 lands on the highest bit of the field
  always_comb begin
    raw_word = '0;
    for (int i = 0; i < SRC_N; i++) begin
      raw_word[FIELD_LSB + SRC_N - 1 - i] = lvl_q[i];
    end
  end

  assign raw_o    = raw_word;
  assign masked_o = raw_word & mask;
  assign irq_o    = |masked_o;

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_bank_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  read_sel_e         sel,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] raw,
  input  logic [DATA_W-1:0] masked,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    unique case (sel)
      RSEL_MASK:   rdata_d = mask;
      RSEL_RAW:    rdata_d = raw;
      RSEL_MASKED: rdata_d = masked;
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_bank_pkg::*;
#(
  parameter int                DATA_W     = 64,
  parameter int                ADDR_W     = 4,
  parameter int                SRC_N      = 16,
  parameter int                FIELD_LSB  = 32,
  parameter logic [ADDR_W-1:0] OFF_MASK   = 4'h8,
  parameter logic [ADDR_W-1:0] OFF_RAW    = 4'h9,
  parameter logic [ADDR_W-1:0] OFF_MASKED = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [SRC_N-1:0]  src_lvl,
  output logic              irq_o
);

  logic              rst_sync_n;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] raw_w;
  logic [DATA_W-1:0] masked_w;
  mask_op_e          mask_op;
  read_sel_e         rd_sel;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  // a shared offset selects a mask update on writes, a condition view on reads
  always_comb begin
    mask_op = MOP_NONE;
    if (reg_wr) begin
      if (reg_addr == OFF_MASK)        mask_op = MOP_LOAD;
      else if (reg_addr == OFF_RAW)    mask_op = MOP_SET;
      else if (reg_addr == OFF_MASKED) mask_op = MOP_CLR;
    end
  end

  always_comb begin
    if (reg_addr == OFF_MASK)        rd_sel = RSEL_MASK;
    else if (reg_addr == OFF_RAW)    rd_sel = RSEL_RAW;
    else if (reg_addr == OFF_MASKED) rd_sel = RSEL_MASKED;
    else                             rd_sel = RSEL_ZERO;
  end

  irq_mask_reg #(
    .DATA_W(DATA_W), .SRC_N(SRC_N), .FIELD_LSB(FIELD_LSB)
  ) u_mask (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .op     (mask_op),
    .wdata  (reg_wdata),
    .mask_o (mask_q)
  );

  irq_cond_view #(
    .DATA_W(DATA_W), .SRC_N(SRC_N), .FIELD_LSB(FIELD_LSB)
  ) u_cond (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .src_lvl  (src_lvl),
    .mask     (mask_q),
    .raw_o    (raw_w),
    .masked_o (masked_w),
    .irq_o    (irq_o)
  );

  irq_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_en   (reg_rd),
    .sel     (rd_sel),
    .mask    (mask_q),
    .raw     (raw_w),
    .masked  (masked_w),
    .rdata_o (reg_rdata)
  );

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
  parameter int                DATA_W     = 64,
  parameter int                ADDR_W     = 4,
  parameter int                SRC_N      = 16,
  parameter int                FIELD_LSB  = 32,
  parameter logic [ADDR_W-1:0] OFF_MASK   = 4'h8,
  parameter logic [ADDR_W-1:0] OFF_RAW    = 4'h9,
  parameter logic [ADDR_W-1:0] OFF_MASKED = 4'hA
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] mask_q,
  input logic              irq_o
);

  localparam logic [DATA_W-1:0] FIELD_MASK =
    {{(DATA_W-SRC_N){1'b0}}, {SRC_N{1'b1}}} << FIELD_LSB;

  logic live_off;
  assign live_off = (reg_addr == OFF_MASK) || (reg_addr == OFF_RAW) ||
                    (reg_addr == OFF_MASKED);

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_MASK) |=> mask_q == ($past(reg_wdata) & FIELD_MASK));

  assert_rdata_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~FIELD_MASK) == '0);

  assert_mask_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_RAW) |=>
      mask_q == ($past(mask_q) | ($past(reg_wdata) & FIELD_MASK)));

  assert_mask_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_MASKED) |=> mask_q == ($past(mask_q) & $past(reg_wdata)));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  assert_other_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr || !live_off) |=> $stable(mask_q));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

endmodule

bind irq_bank irq_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_N(SRC_N), .FIELD_LSB(FIELD_LSB),
  .OFF_MASK(OFF_MASK), .OFF_RAW(OFF_RAW), .OFF_MASKED(OFF_MASKED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .mask_q    (mask_q),
  .irq_o     (irq_o)
);

// File: tb/irq_bank_tb.sv
`timescale 1ns/1ps
module irq_bank_tb;

  localparam int DW = 64;
  localparam int AW = 4;
  localparam int SN = 16;
  localparam int FL = 32;
  localparam logic [DW-1:0] FIELD = {{(DW-SN){1'b0}}, {SN{1'b1}}} << FL;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] reg_addr;
  logic          reg_wr;
  logic          reg_rd;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic [SN-1:0] src_lvl;
  logic          irq_o;

  int checks;
  int failures;

  logic [DW-1:0] m_mask;
  logic [DW-1:0] m_raw;
  logic [DW-1:0] last_exp;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  irq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_lvl(src_lvl), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DW-1:0] map_src(input logic [SN-1:0] s);
    logic [DW-1:0] w = '0;
    for (int i = 0; i < SN; i++) w[FL + SN - 1 - i] = s[i];
    return w;
  endfunction

  function automatic logic [DW-1:0] view(input logic [AW-1:0] a);
    if (a == 4'h8) return m_mask;
    if (a == 4'h9) return m_raw;
    if (a == 4'hA) return m_raw & m_mask;
    return '0;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one clock cycle of stimulus, scoreboard push for reads
  task automatic cyc(input logic wr, input logic rd, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input logic [SN-1:0] s, input string tag);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd; src_lvl = s;
    if (rd) begin
      exp_q.push_back(view(a));
      tag_q.push_back(tag);
      last_exp = view(a);
    end
    @(negedge clk);
    if (wr) begin
      if (a == 4'h8)      m_mask = wd & FIELD;
      else if (a == 4'h9) m_mask = (m_mask | wd) & FIELD;
      else if (a == 4'hA) m_mask = m_mask & wd;
    end
    m_raw = map_src(s);
    check("R7 irq", {63'd0, irq_o}, {63'd0, |(m_raw & m_mask)});
  endtask

  // monitor: compares read data after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && reg_rd) begin
        #5;
        if (exp_q.size() > 0) begin
          check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
      end
    end
  end

  task automatic run_all();
    logic [SN-1:0] s;
    cyc(0, 0, 0, 0, 0, "");
    check("R1 rdata", reg_rdata, '0);
    check("R1 irq", {63'd0, irq_o}, '0);
    cyc(0, 1, 4'h8, 0, 0, "R1 mask read");
    // R2 load, high bits dropped
    cyc(1, 0, 4'h8, '1, 0, "");
    cyc(0, 1, 4'h8, 0, 0, "R2 load all ones");
    cyc(1, 0, 4'h8, 64'h0000_1234_0000_0000, 0, "");
    cyc(0, 1, 4'h8, 0, 0, "R2 load pattern");
    // R3 OR
    cyc(1, 0, 4'h9, 64'hFFFF_8001_FFFF_FFFF, 0, "");
    cyc(0, 1, 4'h8, 0, 0, "R3 or set");
    // R4 AND
    cyc(1, 0, 4'hA, 64'h0000_F00F_0000_0000, 0, "");
    cyc(0, 1, 4'h8, 0, 0, "R4 and clear");
    // R5 mapping end bits
    s = 16'h0001;
    cyc(0, 0, 0, 0, s, "");
    cyc(0, 1, 4'h9, 0, s, "R5 src0 at bit47");
    check("R5 bit47", reg_rdata, 64'h0000_8000_0000_0000);
    s = 16'h8000;
    cyc(0, 0, 0, 0, s, "");
    cyc(0, 1, 4'h9, 0, s, "R5 src15 at bit32");
    s = 16'h0002;
    cyc(0, 0, 0, 0, s, "");
    cyc(0, 1, 4'h9, 0, s, "R5 parity at bit46");
    // R6 masked view with several masks
    s = 16'hA5C3;
    cyc(1, 0, 4'h8, 64'h0000_0FF0_0000_0000, s, "");
    cyc(0, 1, 4'hA, 0, s, "R6 masked view");
    cyc(1, 0, 4'h8, 0, s, "");
    cyc(0, 1, 4'hA, 0, s, "R6 masked zero");
    // R8 writes cannot clear raw
    cyc(1, 0, 4'hA, 0, s, "");
    cyc(1, 0, 4'h9, '1, s, "");
    cyc(0, 1, 4'h9, 0, s, "R8 raw unchanged");
    cyc(0, 0, 0, 0, 0, "");
    cyc(0, 1, 4'h9, 0, 0, "R8 raw follows level");
    // R9 other offsets
    cyc(1, 0, 4'h3, 0, s, "");
    cyc(1, 0, 4'hF, 0, s, "");
    cyc(0, 1, 4'h8, 0, s, "R9 mask unchanged");
    cyc(0, 1, 4'h0, 0, s, "R9 offset 0 zero");
    cyc(0, 1, 4'hB, 0, s, "R9 offset b zero");
    cyc(0, 1, 4'h7, 0, s, "R9 offset 7 zero");
    // R10 read sees pre-write state, then holds
    cyc(1, 1, 4'h8, 0, s, "R10 read before write");
    cyc(0, 0, 0, 0, s, "");
    cyc(0, 0, 4'h9, '1, s, "");
    check("R10 hold", reg_rdata, last_exp);
    // R11 write and source change together
    cyc(1, 0, 4'h9, 64'h0000_00FF_0000_0000, 16'hFF00, "");
    cyc(0, 1, 4'hA, 0, 16'hFF00, "R11 both visible");
    cyc(0, 1, 4'h9, 0, 16'h0000, "R11 raw before drop");
    cyc(0, 1, 4'h9, 0, 16'h0000, "R11 raw after drop");
    cyc(0, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 0, "");
  endtask

  initial begin
    checks = 0; failures = 0;
    m_mask = '0; m_raw = '0; last_exp = '0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; src_lvl = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule